// File: doc/BRIEF.md
# OTP Calibration Shift-Register Controller

This block models the write-once calibration store of a display driver. A 14-cell serial chain sits in front of a 14-cell one-time-programmable array. The array holds an 8-bit offset field, a 5-bit calibration field and a seal cell. Software reaches the chain only while a calibration mode is active. It loads the chain with one command per bit. It then pulses a program strobe, which stands in for the external programming voltages. Every array cell whose chain cell holds 1 is then set for good.

Calibration mode can only be entered after a fixed preparation sequence:
1. the OTP-enable command;
2. leaving power-down;
3. a refresh wait of a parameterised number of cycles;
4. returning to power-down.

A request that breaks this sequence, or that arrives once the seal cell is set, is refused and flagged. The controller also watches each strobe. It warns when more than one cell would be programmed at once, and it flags an attempt to program a cell that is already set. Reset ends each programming pass. Reset clears the chain, the mode state and the flags, but never the array.

Top module: `otp_cal_ctrl`

## Requirements
- R1: A synchronous active-low reset leaves calibration mode off, clears all three flags and empties the chain. It leaves the OTP array and the seal contents unchanged.
- R2: A program strobe while in calibration mode ORs the chain into the array. A chain cell holding 0 leaves its array cell as it was.
- R3: No array cell ever returns from 1 to 0.
- R4: Each SHIFT command moves the chain one place and takes its new bit from cmd_data[0]. After 14 shifts, the first bit shifted in sits at offset bit 7. The following seven land on offset bits 6 down to 0, the next five on calibration bits 4 down to 0, and the last on the seal cell. The array reads out as offset on otp_offset, calibration on otp_cal and seal on otp_sealed.
- R5: Opcodes on cmd_op when cmd_valid is 1 are NOP=0, OTP_EN=1, PWR_UP=2, PWR_DN=3, CAL_ENTER=4 and SHIFT=5. CAL_ENTER is accepted only after OTP_EN, then PWR_UP, then the refresh wait, then PWR_DN, in that order. Any other CAL_ENTER is refused, leaves cal_mode at 0 and sets err_seq.
- R6: The refresh wait is REFRESH_CYCLES clock cycles spent powered up. If PWR_DN comes before the wait completes, the following CAL_ENTER is refused with err_seq.
- R7: Once the seal cell is set, every CAL_ENTER is refused with err_seq.
- R8: A strobe in calibration mode with more than one 1 in the chain sets warn_multi. The cells are still programmed.
- R9: A strobe in calibration mode whose chain has a 1 over an array cell that is already 1 sets err_reprog.
- R10: SHIFT commands and program strobes outside calibration mode change neither the chain nor the array.
- R11: Calibration mode, once entered, stays on across strobes until reset. All flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 8 | Command byte; bit 0 is the serial bit for SHIFT |
| prog_strobe | input | 1 | Program strobe (programming voltage applied) |
| cal_mode | output | 1 | Calibration mode active |
| otp_offset | output | 8 | OTP offset field |
| otp_cal | output | 5 | OTP calibration field |
| otp_sealed | output | 1 | OTP seal cell |
| err_seq | output | 1 | Sticky: calibration entry refused |
| warn_multi | output | 1 | Sticky: strobe with more than one chain bit set |
| err_reprog | output | 1 | Sticky: strobe targeted an already-set cell |

## Verification
The assertions take for granted that at most one command is presented per cycle and that reset is low for at least one full clock edge. They also assume the array starts unprogrammed at power-up, before the first reset. The stimulus drives one command or strobe per cycle between clock edges. It waits well past the refresh count when a pass should succeed, and only two cycles when one should fail. It reaches the seal cell only in the last pass, so that the earlier passes can still enter calibration mode.

// File: rtl/otpc_pkg.sv
// Shared opcode and sequencer state types for the OTP calibration controller.
// Assumes a 3-bit opcode field on the command port.
package otpc_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_OTP_EN    = 3'd1,
        OP_PWR_UP    = 3'd2,
        OP_PWR_DN    = 3'd3,
        OP_CAL_ENTER = 3'd4,
        OP_SHIFT     = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ENABLED = 3'd1,
        ST_POWERED = 3'd2,
        ST_ARMED   = 3'd3,
        ST_CAL     = 3'd4
    } seq_e;

endpackage

// File: rtl/otpc_seq.sv
// Entry sequencer: tracks enable / power-up / refresh / power-down ordering
// and grants calibration mode. Refresh wait is a cycle counter.
// Assumes one command per cycle; the seal input comes from the OTP array.
module otpc_seq
    import otpc_pkg::*;
#(
    parameter int REFRESH_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  op_e  cmd_op,
    input  logic sealed,
    output logic cal_mode,
    output logic err_seq
);
    localparam int CW = $clog2(REFRESH_CYCLES + 1);
    localparam logic [CW-1:0] REF_LAST = CW'(REFRESH_CYCLES);

    seq_e          state_q;
    logic [CW-1:0] cnt_q;
    logic          ok_q;
    logic          cal_req;
    logic          grant;

    assign cal_req  = cmd_valid && (cmd_op == OP_CAL_ENTER) && (state_q != ST_CAL);
    assign grant    = (state_q == ST_ARMED) && ok_q && !sealed;
    assign cal_mode = (state_q == ST_CAL);

    // Advance the entry sequence and run the refresh counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ok_q    <= 1'b0;
            err_seq <= 1'b0;
        end else begin
            if (state_q == ST_POWERED && cnt_q != REF_LAST)
                cnt_q <= cnt_q + 1'b1;
            if (cmd_valid) begin
                unique case (state_q)
                    ST_IDLE:    if (cmd_op == OP_OTP_EN) state_q <= ST_ENABLED;
                    ST_ENABLED: if (cmd_op == OP_PWR_UP) begin
                                    state_q <= ST_POWERED;
                                    cnt_q   <= '0;
                                end
                    ST_POWERED: if (cmd_op == OP_PWR_DN) begin
                                    state_q <= ST_ARMED;
                                    ok_q    <= (cnt_q == REF_LAST);
                                end
                    ST_ARMED:   ;
                    ST_CAL:     ;
                    default:    state_q <= ST_IDLE;
                endcase
                if (cal_req) begin
                    if (grant) state_q <= ST_CAL;
                    else       err_seq <= 1'b1;
                end
            end
        end
    end

    AST_ENTRY_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_mode && !(state_q == ST_ARMED && ok_q && !sealed)) |=> !cal_mode); // R5

    AST_SEALED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed && !cal_mode) |=> !cal_mode); // R7

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cal_mode |=> cal_mode); // R11

endmodule

// File: rtl/otpc_chain.sv
// Serial shift chain: one cell per OTP bit, shifted toward the MSB so the
// first bit loaded ends in the top cell. Only moves in calibration mode.
module otpc_chain
    import otpc_pkg::*;
#(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  op_e          cmd_op,
    input  logic         ser_bit,
    input  logic         cal_active,
    output logic [N-1:0] chain
);
    logic shift_en;
    assign shift_en = cal_active && cmd_valid && (cmd_op == OP_SHIFT);

    // Shift one position per accepted SHIFT command.
    always_ff @(posedge clk) begin
        if (!rst_n)        chain <= '0;
        else if (shift_en) chain <= {chain[N-2:0], ser_bit};
    end

    AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_active |=> $stable(chain)); // R10

endmodule

// File: rtl/otpc_array.sv
// Write-once OTP array: a strobe in calibration mode ORs the chain in.
// Raises sticky warnings for multi-bit and repeat programming.
// The array has no reset; power-up contents are all zero (unprogrammed).
module otpc_array #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         cal_active,
    input  logic [N-1:0] chain,
    output logic [N-1:0] otp,
    output logic         warn_multi,
    output logic         err_reprog
);
    logic [N-1:0] otp_q = '0;
    logic         fire;

    assign fire = strobe && cal_active;
    assign otp  = otp_q;

    // Program set cells; cells never clear.
    always_ff @(posedge clk) begin
        if (fire) otp_q <= otp_q | chain;
    end

    // Track the sticky strobe warnings, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_multi <= 1'b0;
            err_reprog <= 1'b0;
        end else if (fire) begin
            if ($countones(chain) > 1) warn_multi <= 1'b1;
            if (|(chain & otp_q))      err_reprog <= 1'b1;
        end
    end

    AST_OTP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((otp_q & $past(otp_q)) == $past(otp_q))); // R3

    AST_NO_PROG_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cal_active) |=> $stable(otp_q)); // R10

    AST_MULTI_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cal_active && $countones(chain) > 1) |=> warn_multi); // R8

    AST_REPROG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cal_active && (chain & otp_q) != '0) |=> err_reprog); // R9

endmodule

// File: rtl/otp_cal_ctrl.sv
// Top of the OTP calibration controller: sequencer, shift chain and array.
// Chain/array layout, MSB first: offset field, calibration field, seal cell.
module otp_cal_ctrl
    import otpc_pkg::*;
#(
    parameter int OFS_W          = 8,
    parameter int CAL_W          = 5,
    parameter int REFRESH_CYCLES = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_data,
    input  logic             prog_strobe,
    output logic             cal_mode,
    output logic [OFS_W-1:0] otp_offset,
    output logic [CAL_W-1:0] otp_cal,
    output logic             otp_sealed,
    output logic             err_seq,
    output logic             warn_multi,
    output logic             err_reprog
);
    localparam int N = OFS_W + CAL_W + 1;

    op_e          op;
    logic [N-1:0] chain;
    logic [N-1:0] otp;

    assign op         = op_e'(cmd_op);
    assign otp_offset = otp[N-1 -: OFS_W];
    assign otp_cal    = otp[CAL_W:1];
    assign otp_sealed = otp[0];

    otpc_seq #(.REFRESH_CYCLES(REFRESH_CYCLES)) i_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op),
        .sealed(otp[0]), .cal_mode(cal_mode), .err_seq(err_seq)
    );

    otpc_chain #(.N(N)) i_chain (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op),
        .ser_bit(cmd_data[0]), .cal_active(cal_mode), .chain(chain)
    );

    otpc_array #(.N(N)) i_array (
        .clk(clk), .rst_n(rst_n), .strobe(prog_strobe), .cal_active(cal_mode),
        .chain(chain), .otp(otp), .warn_multi(warn_multi), .err_reprog(err_reprog)
    );

endmodule

// File: tb/test_otp_cal_ctrl.sv
// Self-checking bench: table of programming passes, then directed cases.
module test_otp_cal_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int REF        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       prog_strobe = 1'b0;
    logic       cal_mode, otp_sealed, err_seq, warn_multi, err_reprog;
    logic [7:0] otp_offset;
    logic [4:0] otp_cal;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    otp_cal_ctrl #(.REFRESH_CYCLES(REF)) i_otp_cal_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .prog_strobe(prog_strobe), .cal_mode(cal_mode),
        .otp_offset(otp_offset), .otp_cal(otp_cal), .otp_sealed(otp_sealed),
        .err_seq(err_seq), .warn_multi(warn_multi), .err_reprog(err_reprog)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pass table: {chain pattern[13:0], expected otp[13:0], mode, err_seq, warn, reprog}
    localparam int NP = 5;
    localparam logic [31:0] PASSES [0:NP-1] = '{
        {14'h0400, 14'h0400, 4'b1000},   // R2 R4: offset bit 4
        {14'h0002, 14'h0402, 4'b1000},   // R4: calibration bit 0
        {14'h0060, 14'h0462, 4'b1010},   // R8: two cells at once
        {14'h0400, 14'h0462, 4'b1001},   // R9: cell already set
        {14'h0000, 14'h0462, 4'b1000}    // R2: zeros change nothing
    };

    function automatic logic [13:0] otp_now();
        return {otp_offset, otp_cal, otp_sealed};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic dat, input logic stb, input logic vld);
        @(negedge clk);
        cmd_valid = vld; cmd_op = op; cmd_data = {7'd0, dat}; prog_strobe = stb;
        @(posedge clk); #1;
        cmd_valid = 1'b0; prog_strobe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
    endtask

    task automatic prep(input int waits);
        drive(3'd1, 1'b0, 1'b0, 1'b1);
        drive(3'd2, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < waits; i++) drive(3'd0, 1'b0, 1'b0, 1'b1);
        drive(3'd3, 1'b0, 1'b0, 1'b1);
        drive(3'd4, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic load(input logic [13:0] pat);
        for (int i = 13; i >= 0; i--) drive(3'd5, pat[i], 1'b0, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk); cycles++;
            if (cycles > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <100000", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        check("R1 reset state", {12'd0, cal_mode, err_seq, warn_multi, err_reprog}, 16'd0);
        check("R1 otp blank", {2'd0, otp_now()}, 16'd0);

        for (int p = 0; p < NP; p++) begin
            do_reset();
            prep(REF + 3);
            check("R5 entry granted", {15'd0, cal_mode}, 16'd1);
            load(PASSES[p][31:18]);
            drive(3'd0, 1'b0, 1'b1, 1'b0);
            check("R2 R4 otp after strobe", {2'd0, otp_now()}, {2'd0, PASSES[p][17:4]});
            check("R8 R9 R11 mode and flags",
                  {12'd0, cal_mode, err_seq, warn_multi, err_reprog}, {12'd0, PASSES[p][3:0]});
        end

        // R6: power-down before the refresh wait completes.
        do_reset();
        prep(2);
        check("R6 early entry refused", {14'd0, cal_mode, err_seq}, 16'b01);

        // R5: entry without any preparation.
        do_reset();
        drive(3'd4, 1'b0, 1'b0, 1'b1);
        check("R5 unprepared entry refused", {14'd0, cal_mode, err_seq}, 16'b01);

        // R10 and R1: shift/strobe outside the mode; chain emptied by reset.
        do_reset();
        drive(3'd5, 1'b1, 1'b0, 1'b1);
        drive(3'd0, 1'b0, 1'b1, 1'b0);
        check("R10 strobe outside mode", {2'd0, otp_now()}, 16'h0462);
        prep(REF + 3);
        drive(3'd0, 1'b0, 1'b1, 1'b0);
        check("R10 R1 chain empty at strobe",
              {13'd0, warn_multi, err_reprog, cal_mode}, 16'b001);
        check("R10 R1 otp unchanged", {2'd0, otp_now()}, 16'h0462);

        // R7: program the seal cell, then try to re-enter.
        do_reset();
        prep(REF + 3);
        load(14'h0001);
        drive(3'd0, 1'b0, 1'b1, 1'b0);
        check("R4 seal programmed", {15'd0, otp_sealed}, 16'd1);
        check("R11 mode held after strobe", {15'd0, cal_mode}, 16'd1);
        do_reset();
        check("R1 otp kept over reset", {1'b0, cal_mode, otp_now()}, 16'h0463);
        prep(REF + 3);
        check("R7 sealed entry refused", {14'd0, cal_mode, err_seq}, 16'b01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule